// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches one 16-bit word at a time from a three-wire serial EEPROM. It owns the chip-select, serial-clock and serial-data-to-memory pins and samples the memory's serial data output. A host presents a word address, an address width and a one-cycle start strobe. The block then runs a fixed sequence: a settle interval, a zero lead-in bit, the read opcode, the address and sixteen data clocks. It ends by returning the assembled word together with a one-cycle done pulse.

All pin timing is made of equal phase intervals, each lasting a host-programmed number of system clocks. The phase length and address width are captured when a start is accepted. Every word repeats the whole select-and-command sequence. No burst reads are done. The host can pick 6, 7 or 8 address bits per word. Other widths are clamped into that range and reported on an error flag.

Top module: `mw_eeprom_reader`

## Requirements
- R1: After reset, chip select, serial clock, serial data-in, busy, done and the length error flag are all low, and the data output is zero.
- R2: After an accepted start, chip select goes high with the serial clock low and stays that way for one settle interval. The first serial clock rise then comes two intervals after chip select rises.
- R3: The bits shifted to the memory are 0, 1, 1, 0, in that order. They are followed by the low L bits of the address, most significant first, where L is the effective address width.
- R4: Each bit sent to the memory takes three intervals: data set with the clock low, clock high, clock low. Data-in never changes while the clock is high.
- R5: Sixteen data bits follow the address. For each one the clock is high for two intervals, the memory output is sampled at the end of the second, and the clock is then low for one interval. Bits fill the word most significant first.
- R6: Address widths below 6 become 6 and widths above 8 become 8. The length error flag is set on an accepted start whose width was out of range, is cleared on an accepted start whose width was in range, and otherwise holds.
- R7: One interval lasts div_i system clocks, and a div_i of 0 counts as 1. The divider is 16 bits, so a 250 microsecond interval is reachable at clocks up to 262 MHz.
- R8: done_o is high for exactly one cycle. It rises (1 + 3*(20+L)) * D clock edges after the edge that accepts the start, where D is the interval length. In that cycle chip select and busy are low and data_o holds the new word, which stays until the next done.
- R9: busy_o is high from the cycle after an accepted start until done. A start while busy is ignored and does not change the address, width, result or timing of the word in progress.
- R10: The serial clock is high only while chip select is high. Each word gives exactly 20+L clock pulses inside its own chip-select window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to read a word |
| addr_i | input | 8 | Word address; low L bits are used |
| addr_len_i | input | 4 | Requested address width in bits |
| div_i | input | 16 | Interval length in system clocks |
| busy_o | output | 1 | A word read is in progress |
| done_o | output | 1 | One-cycle pulse, word is ready |
| data_o | output | 16 | Last word read |
| len_err_o | output | 1 | Last accepted width was clamped |
| cs_o | output | 1 | Memory chip select |
| sk_o | output | 1 | Memory serial clock |
| di_o | output | 1 | Serial data to the memory |
| do_i | input | 1 | Serial data from the memory |

## Verification
Each word's result is due a fixed (1 + 3*(20+L)) * D clock edges after the accepting edge. The bench counts edges from that edge and compares the count at which done is first seen with the figure worked out from the clamped width and the effective interval. Word, error flag and busy are read at the falling edge in the done cycle, and done is read again one cycle later to confirm it has dropped. Pin timing is followed by a monitor that samples on falling edges. It measures the delay from chip-select rise to the first clock rise (2D) and the length of each clock-high run: D for command bits and 2D for data bits.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_TX     = 2'd2,
    ST_RX     = 2'd3
  } seq_state_t;

  // lead-in zero followed by the read opcode, sent left to right
  localparam int unsigned LEAD_W    = 4;
  localparam logic [3:0]  LEAD_BITS = 4'b0110;

  // phase indices inside one bit slot
  localparam logic [1:0] PH_A = 2'd0;
  localparam logic [1:0] PH_B = 2'd1;
  localparam logic [1:0] PH_C = 2'd2;

  function automatic int unsigned clamp_len(int unsigned raw, int unsigned lo,
                                            int unsigned hi);
    if (raw < lo) return lo;
    if (raw > hi) return hi;
    return raw;
  endfunction

  function automatic logic len_outside(int unsigned raw, int unsigned lo,
                                       int unsigned hi);
    return (raw < lo) || (raw > hi);
  endfunction

  function automatic int unsigned word_intervals(int unsigned len,
                                                 int unsigned data_w);
    return 1 + 3 * (LEAD_W + len + data_w);
  endfunction

  function automatic int unsigned eff_div(int unsigned div);
    return (div == 0) ? 1 : div;
  endfunction

endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             run_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] len_q;
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == len_q - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= DIV_W'(1);
      cnt_q <= '0;
    end else if (load_i) begin
      len_q <= (div_i == '0) ? DIV_W'(1) : div_i;
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mw_tx_shifter.sv
module mw_tx_shifter
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_MAX = 8,
  parameter int LEN_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [ADDR_MAX-1:0] addr_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                shift_i,
  output logic                bit_o,
  output logic                last_o
);
  localparam int FRAME_W = LEAD_W + ADDR_MAX;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [LEN_W-1:0] AMAX = LEN_W'(ADDR_MAX);

  logic [FRAME_W-1:0]  frame_q;
  logic [CNT_W-1:0]    left_q;
  logic [ADDR_MAX-1:0] addr_aligned;

  // push the used address bits up against the opcode
  assign addr_aligned = addr_i << (AMAX - len_i);
  assign bit_o  = frame_q[FRAME_W-1];
  assign last_o = (left_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      left_q  <= '0;
    end else if (load_i) begin
      frame_q <= {LEAD_BITS, addr_aligned};
      left_q  <= CNT_W'(LEAD_W) + CNT_W'(len_i);
    end else if (shift_i) begin
      frame_q <= {frame_q[FRAME_W-2:0], 1'b0};
      left_q  <= left_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/mw_rx_shifter.sv
module mw_rx_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] word_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_o <= '0;
    else if (clear_i)  word_o <= '0;
    else if (sample_i) word_o <= {word_o[DATA_W-2:0], din_i};
  end
endmodule

// File: rtl/mw_eeprom_reader.sv
module mw_eeprom_reader
  import mw_eeprom_pkg::*;
#(
  parameter int ADDR_MIN = 6,
  parameter int ADDR_MAX = 8,
  parameter int LEN_W    = 4,
  parameter int DIV_W    = 16,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [ADDR_MAX-1:0] addr_i,
  input  logic [LEN_W-1:0]    addr_len_i,
  input  logic [DIV_W-1:0]    div_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [DATA_W-1:0]   data_o,
  output logic                len_err_o,
  output logic                cs_o,
  output logic                sk_o,
  output logic                di_o,
  input  logic                do_i
);
  localparam int RXC_W = $clog2(DATA_W);

  seq_state_t       state_q;
  logic [1:0]       ph_q;
  logic [RXC_W-1:0] rx_cnt_q;

  // named internal events
  logic             accept_w;
  logic             tick_w;
  logic             slot_end_w;
  logic             tx_shift_w;
  logic             tx_last_w;
  logic             tx_bit_w;
  logic             sample_w;
  logic             word_end_w;
  logic [LEN_W-1:0] len_eff_w;
  logic             len_bad_w;
  logic [DATA_W-1:0] rx_word_w;

  assign accept_w   = start_i && (state_q == ST_IDLE);
  assign len_eff_w  = LEN_W'(clamp_len(32'(addr_len_i), ADDR_MIN, ADDR_MAX));
  assign len_bad_w  = len_outside(32'(addr_len_i), ADDR_MIN, ADDR_MAX);
  assign slot_end_w = tick_w && (ph_q == PH_C);
  assign tx_shift_w = slot_end_w && (state_q == ST_TX) && !tx_last_w;
  assign sample_w   = tick_w && (state_q == ST_RX) && (ph_q == PH_B);
  assign word_end_w = slot_end_w && (state_q == ST_RX) &&
                      (rx_cnt_q == RXC_W'(DATA_W - 1));

  mw_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept_w),
    .div_i  (div_i),
    .run_i  (state_q != ST_IDLE),
    .tick_o (tick_w)
  );

  mw_tx_shifter #(.ADDR_MAX(ADDR_MAX), .LEN_W(LEN_W)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (accept_w),
    .addr_i  (addr_i),
    .len_i   (len_eff_w),
    .shift_i (tx_shift_w),
    .bit_o   (tx_bit_w),
    .last_o  (tx_last_w)
  );

  mw_rx_shifter #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (accept_w),
    .sample_i (sample_w),
    .din_i    (do_i),
    .word_o   (rx_word_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      ph_q     <= PH_A;
      rx_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept_w) begin
          state_q <= ST_SETTLE;
          ph_q    <= PH_A;
        end
        ST_SETTLE: if (tick_w) begin
          state_q <= ST_TX;
          ph_q    <= PH_A;
        end
        ST_TX: if (tick_w) begin
          if (ph_q == PH_C) begin
            ph_q <= PH_A;
            if (tx_last_w) begin
              state_q  <= ST_RX;
              rx_cnt_q <= '0;
            end
          end else begin
            ph_q <= ph_q + 2'd1;
          end
        end
        ST_RX: if (tick_w) begin
          if (ph_q == PH_C) begin
            ph_q <= PH_A;
            if (word_end_w) state_q  <= ST_IDLE;
            else            rx_cnt_q <= rx_cnt_q + RXC_W'(1);
          end else begin
            ph_q <= ph_q + 2'd1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_o    <= 1'b0;
      data_o    <= '0;
      len_err_o <= 1'b0;
    end else begin
      done_o <= word_end_w;
      if (word_end_w) data_o    <= rx_word_w;
      if (accept_w)   len_err_o <= len_bad_w;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign cs_o   = (state_q != ST_IDLE);
  assign sk_o   = ((state_q == ST_TX) && (ph_q == PH_B)) ||
                  ((state_q == ST_RX) && (ph_q != PH_C));
  assign di_o   = (state_q == ST_TX) ? tx_bit_w : 1'b0;

endmodule

// File: rtl/mw_eeprom_reader_chk.sv
module mw_eeprom_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic accept,
  input logic sample,
  input logic busy_o,
  input logic done_o,
  input logic len_err_o,
  input logic cs_o,
  input logic sk_o,
  input logic di_o
);
  // R10
  sk_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sk_o |-> cs_o);

  // R4
  di_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_o && $past(sk_o)) |-> $stable(di_o));

  // R5
  sample_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> sk_o);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!cs_o && !busy_o));

  // R8
  cs_drop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_o) |-> done_o);

  // R6
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(accept) |-> $stable(len_err_o));

  // R2
  select_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy_o && cs_o && !sk_o));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |-> !accept);
endmodule

bind mw_eeprom_reader mw_eeprom_reader_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .accept    (accept_w),
  .sample    (sample_w),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .len_err_o (len_err_o),
  .cs_o      (cs_o),
  .sk_o      (sk_o),
  .di_o      (di_o)
);

// File: tb/mw_eeprom_reader_test.sv
`timescale 1ns/1ps
module mw_eeprom_reader_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [3:0]  addr_len_i = 4'd7;
  logic [15:0] div_i = 16'd1;
  logic        busy_o, done_o, len_err_o, cs_o, sk_o, di_o;
  logic [15:0] data_o;
  logic        do_i = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit wd_hit = 0;

  always #2.5 clk = ~clk;

  mw_eeprom_reader uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
    .addr_len_i(addr_len_i), .div_i(div_i), .busy_o(busy_o), .done_o(done_o),
    .data_o(data_o), .len_err_o(len_err_o), .cs_o(cs_o), .sk_o(sk_o),
    .di_o(di_o), .do_i(do_i)
  );

  // ---------------- bench arithmetic ----------------
  function automatic int clampw(int raw);
    return (raw < 6) ? 6 : ((raw > 8) ? 8 : raw);
  endfunction

  function automatic logic [15:0] mem_word(int a);
    int m;
    m = a & 127;
    return 16'((m * 40503) ^ 16'h5A3C ^ (m << 9));
  endfunction

  function automatic int due_edges(int len, int d);
    return (1 + 3 * (len + 20)) * d;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  int          mdl_len = 7;
  int          md_cnt = 0;
  logic [15:0] md_shift = '0;
  logic [3:0]  md_lead = '0;
  int          md_addr = 0;

  always @(posedge sk_o or posedge cs_o) begin
    if (!sk_o) begin
      md_cnt = 0;
      md_shift = '0;
      do_i = 1'b0;
    end else begin
      md_cnt++;
      if (md_cnt <= 4 + mdl_len) begin
        md_shift = {md_shift[14:0], di_o};
        if (md_cnt == 4 + mdl_len) begin
          md_lead = 4'(md_shift >> mdl_len);
          md_addr = int'(md_shift) & ((1 << mdl_len) - 1);
        end
      end else begin
        int k;
        logic [15:0] w;
        k = md_cnt - 5 - mdl_len;
        w = mem_word(md_addr);
        if (k < 16) do_i = w[15-k];
      end
    end
  end

  // ---------------- pin monitor ----------------
  int   mon_d = 1, mon_l = 7;
  int   m_since = 0, m_run = 0, m_pulses = 0;
  int   e_r2 = 0, e_r4 = 0, e_r5 = 0, e_r10 = 0;
  logic m_cs = 0, m_sk = 0, m_di = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      m_cs = 0; m_sk = 0; m_di = 0;
    end else begin
      if (sk_o && !cs_o) e_r10++;
      if (cs_o && !m_cs) begin
        m_since = 1; m_pulses = 0;
        if (sk_o) e_r2++;
      end else if (cs_o) m_since++;
      if (sk_o && !m_sk) begin
        m_pulses++; m_run = 1;
        if (m_pulses == 1 && m_since != 2 * mon_d + 1) e_r2++;
      end else if (sk_o) begin
        m_run++;
        if (di_o != m_di) e_r4++;
      end else if (m_sk) begin
        if (m_pulses <= 4 + mon_l) begin
          if (m_run != mon_d) e_r4++;
        end else if (m_run != 2 * mon_d) e_r5++;
      end
      m_cs = cs_o; m_sk = sk_o; m_di = di_o;
    end
  end

  // ---------------- one word ----------------
  task automatic run_word(int addr, int len_raw, int div, bit inject);
    int L, D, cnt, lim, mask;
    bit busy_ok;
    L = clampw(len_raw);
    D = (div == 0) ? 1 : div;
    mask = (1 << L) - 1;
    mdl_len = L; mon_d = D; mon_l = L;
    e_r2 = 0; e_r4 = 0; e_r5 = 0; e_r10 = 0;
    lim = due_edges(L, D) + 50;
    busy_ok = 1;
    @(negedge clk);
    addr_i = 8'(addr); addr_len_i = 4'(len_raw); div_i = 16'(div);
    start_i = 1'b1;
    @(posedge clk);
    cnt = 0;
    while (1) begin
      @(negedge clk);
      start_i = 1'b0;
      if (done_o || cnt > lim) break;
      if (!busy_o) busy_ok = 0;
      if (inject && cnt == 10) begin
        start_i = 1'b1;
        addr_i = ~addr_i;
        addr_len_i = (len_raw == 6) ? 4'd8 : 4'd6;
        div_i = 16'(D + 3);
      end
      @(posedge clk);
      cnt++;
    end
    check(cnt == due_edges(L, D), "R8 done latency", cnt, due_edges(L, D));
    check(data_o == mem_word(addr & mask), "R5 data word", int'(data_o),
          int'(mem_word(addr & mask)));
    check(len_err_o == (len_raw < 6 || len_raw > 8), "R6 length error",
          int'(len_err_o), int'(len_raw < 6 || len_raw > 8));
    check(md_lead == 4'b0110, "R3 lead and opcode", int'(md_lead), 6);
    check(md_addr == (addr & mask), "R3 address bits", md_addr, addr & mask);
    check(!cs_o && !busy_o, "R8 released at done", int'({cs_o, busy_o}), 0);
    check(busy_ok, "R9 busy until done", int'(busy_ok), 1);
    check(e_r2 == 0, "R2 settle timing", e_r2, 0);
    check(e_r4 == 0, "R4 write bit phases", e_r4, 0);
    check(e_r5 == 0, "R5 read bit phases", e_r5, 0);
    check(e_r10 == 0 && m_pulses == 20 + L, "R10 clock pulses in frame",
          m_pulses, 20 + L);
    @(negedge clk);
    check(!done_o, "R8 done one cycle", int'(done_o), 0);
    check(data_o == mem_word(addr & mask), "R8 data held", int'(data_o),
          int'(mem_word(addr & mask)));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    wd_hit = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check({cs_o, sk_o, di_o, busy_o, done_o, len_err_o} == 6'b0 && data_o == 16'h0,
          "R1 reset state", int'({cs_o, sk_o, di_o, busy_o, done_o, len_err_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!cs_o && !busy_o, "R1 idle after reset", int'({cs_o, busy_o}), 0);

    run_word(0, 7, 1, 0);           // R3 all-zero address
    run_word(127, 7, 2, 0);         // R3 all-one address
    run_word(63, 6, 1, 0);          // R6 shortest width
    run_word(200, 8, 3, 0);         // R6 widest width
    run_word(45, 3, 1, 0);          // R6 clamp up, flag set
    run_word(99, 12, 2, 0);         // R6 clamp down, flag set
    run_word(17, 7, 1, 0);          // R6 flag cleared
    run_word(5, 7, 0, 0);           // R7 zero divider
    run_word(90, 7, 20, 0);         // R7 long interval
    run_word(33, 7, 2, 1);          // R9 start while busy
    run_word(21, 15, 1, 1);         // R9 start while busy, clamped width

    for (int a = 0; a < 128; a++)   // R3 R5 every address
      run_word(a, 7, 1 + int'($urandom_range(2)), 0);

    for (int i = 0; i < 30; i++)
      run_word(int'($urandom_range(255)), int'($urandom_range(15)),
               int'($urandom_range(3)), (i % 7) == 3);

    if (!wd_hit) begin
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule